// File: doc/BRIEF.md
# SPI Configuration Preload and Trigger Sequencer

This block loads a fixed set of 16-bit setup words into an external waveform DAC over a three-wire SPI link, commits them and then starts playback. A single start pulse launches the whole sequence. Chip select falls, one instruction word goes out carrying the write flag and the first register address, and the data words for every register follow with chip select held low. The device steps its own address after each word.

Chip select then rises for a guard interval. A second, short transaction writes the commit value to the update register. After that the trigger output is driven high for a fixed time and then low for the same time, and a one-cycle completion pulse closes the run. The setup words come from a small table computed inside the block. The block never reads anything back from the device.

Top module: `cfg_spi_loader`

## Requirements
- R1: While reset is held and after it is released with no start pulse, cs_n_o is 1, sclk_o is 0, trig_o is 0, busy_o is 0 and done_o is 0.
- R2: Every frame word is 16 bits, sent most significant bit first. sdio_o changes only while sclk_o is low and is stable while sclk_o is high. sclk_o idles low and each high phase lasts HALF_DIV system clocks (default 2). No partial word is ever left under chip select.
- R3: The first transaction is one instruction word {WRITE_FLAG, 15-bit address} with the default flag 0 (write) and address 0x0000, followed by N_WORDS (128) data words, all under a single chip-select low period. That makes 129 words in total.
- R4: The data word for register address a (0x00 to 0x7F) is {a[7:0] XOR 0xC3, a[7:0]}. With device-side auto-increment, each address receives exactly its own word.
- R5: Between the burst and the commit transaction, cs_n_o stays high for at least two SPI clock periods (4*HALF_DIV system clocks).
- R6: The second transaction holds exactly two words: the instruction 0x001D (write flag 0, address 0x1D) and the data word 0x0001. Register 0x1D therefore ends at 0x0001.
- R7: trig_o rises only after the commit transaction has closed, with register 0x1D as the last write and 129 writes done in total. It stays high for TRIG_CYC (16) system clocks, then low for TRIG_CYC system clocks before completion.
- R8: busy_o goes high on the clock after an accepted start and stays high through the whole trigger low phase. done_o is high for exactly one clock, in the first cycle in which busy_o is low.
- R9: A start pulse that arrives while busy_o is high is ignored. No extra transaction is opened, and the sequence in progress completes unchanged.
- R10: After done_o the block returns to idle, and a new start pulse repeats the whole sequence with the same words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse that launches the sequence |
| sclk_o | output | 1 | SPI serial clock, idles low |
| cs_n_o | output | 1 | SPI chip select, active low |
| sdio_o | output | 1 | SPI serial data to the device |
| trig_o | output | 1 | Playback trigger to the device |
| busy_o | output | 1 | High while a sequence is running |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench uses a behavioural auto-incrementing slave to check which word lands at each address. A design that reopened the instruction for every word, or let chip select rise inside the burst, would corrupt every address after the break or shift the whole table. The ordering around the trigger is checked separately. A trigger that rose before the commit closed would show a last-written address other than 0x1D, and a chip-select gap that was too short or a commit frame with extra words would show up in the per-transaction counts. A start pulse injected mid-burst catches a design that restarts or stacks a second run, and a second full run catches state left over from the first.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  localparam int FRAME_W = 16;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_INSTR,
    ST_BURST,
    ST_GAP,
    ST_UPD_I,
    ST_UPD_D,
    ST_TRIG_H,
    ST_TRIG_L,
    ST_FIN
  } seq_state_e;

  function automatic logic [FRAME_W-1:0] mk_instr(input logic wr_flag,
                                                   input logic [FRAME_W-2:0] addr);
    return {wr_flag, addr};
  endfunction

endpackage

// File: rtl/cfgl_rst_sync.sv
module cfgl_rst_sync (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_o = sync_q;

endmodule

// File: rtl/cfgl_cfg_rom.sv
module cfgl_cfg_rom #(
  parameter int          N_WORDS    = 128,
  parameter logic [14:0] START_ADDR = 15'h0000,
  localparam int         AW         = (N_WORDS > 1) ? $clog2(N_WORDS) : 1
) (
  input  logic [AW-1:0] idx_i,
  output logic [15:0]   word_o
);

  logic [14:0] reg_addr;

  always_comb begin
    reg_addr = START_ADDR + 15'(idx_i);
    word_o   = {reg_addr[7:0] ^ 8'hC3, reg_addr[7:0]};
  end

endmodule

// File: rtl/cfgl_spi_shifter.sv
module cfgl_spi_shifter #(
  parameter int  W        = 16,
  parameter int  HALF_DIV = 2,
  localparam int DCW      = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1,
  localparam int BCW      = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] word_i,
  output logic         sclk_o,
  output logic         sdio_o,
  output logic         done_o
);

  logic           active_q, active_d;
  logic           sclk_q, sclk_d;
  logic [DCW-1:0] div_q, div_d;
  logic [BCW-1:0] bit_q, bit_d;
  logic [W-1:0]   sh_q, sh_d;
  logic           tick;
  logic           last;

  assign tick = active_q && (div_q == DCW'(HALF_DIV - 1));
  assign last = tick && sclk_q && (bit_q == '0);

  always_comb begin
    active_d = active_q;
    sclk_d   = sclk_q;
    div_d    = div_q;
    bit_d    = bit_q;
    sh_d     = sh_q;
    if (load_i) begin
      active_d = 1'b1;
      sclk_d   = 1'b0;
      div_d    = '0;
      bit_d    = BCW'(W - 1);
      sh_d     = word_i;
    end else if (active_q) begin
      if (tick) begin
        div_d = '0;
        if (!sclk_q) begin
          sclk_d = 1'b1;
        end else begin
          sclk_d = 1'b0;
          if (bit_q == '0) begin
            active_d = 1'b0;
          end else begin
            bit_d = bit_q - 1'b1;
            sh_d  = {sh_q[W-2:0], 1'b0};
          end
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      div_q    <= '0;
      bit_q    <= '0;
      sh_q     <= '0;
    end else begin
      active_q <= active_d;
      sclk_q   <= sclk_d;
      div_q    <= div_d;
      bit_q    <= bit_d;
      sh_q     <= sh_d;
    end
  end

  assign sclk_o = sclk_q;
  assign sdio_o = sh_q[W-1];
  assign done_o = last;

  AST_SDIO_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_o |-> $stable(sdio_o)); // R2

  AST_LOAD_WHEN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> (!active_q || last)); // R2

endmodule

// File: rtl/cfg_spi_loader.sv
module cfg_spi_loader
  import cfgl_pkg::*;
#(
  parameter int          HALF_DIV   = 2,
  parameter int          N_WORDS    = 128,
  parameter logic [14:0] START_ADDR = 15'h0000,
  parameter logic        WRITE_FLAG = 1'b0,
  parameter logic [14:0] UPD_ADDR   = 15'h001D,
  parameter logic [15:0] UPD_DATA   = 16'h0001,
  parameter int          GAP_SPI    = 2,
  parameter int          TRIG_CYC   = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic sclk_o,
  output logic cs_n_o,
  output logic sdio_o,
  output logic trig_o,
  output logic busy_o,
  output logic done_o
);

  localparam int AW      = (N_WORDS > 1) ? $clog2(N_WORDS) : 1;
  localparam int GAP_CYC = 2 * HALF_DIV * GAP_SPI;
  localparam int CNT_MAX = (GAP_CYC > TRIG_CYC) ? GAP_CYC : TRIG_CYC;
  localparam int CNW     = $clog2(CNT_MAX + 1);

  logic           rst_n_s;
  seq_state_e     state_q, state_d;
  logic [AW-1:0]  idx_q, idx_d;
  logic [CNW-1:0] cnt_q, cnt_d;
  logic           cs_n_q, cs_n_d;
  logic           trig_q, trig_d;
  logic           busy_q, busy_d;
  logic           done_q, done_d;
  logic           load;
  logic [15:0]    word_mux;
  logic [AW-1:0]  rom_idx;
  logic [15:0]    rom_word;
  logic           sh_done;

  cfgl_rst_sync u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  assign rom_idx = (state_q == ST_BURST) ? (idx_q + 1'b1) : '0;

  cfgl_cfg_rom #(
    .N_WORDS    (N_WORDS),
    .START_ADDR (START_ADDR)
  ) u_rom (
    .idx_i  (rom_idx),
    .word_o (rom_word)
  );

  cfgl_spi_shifter #(
    .W        (FRAME_W),
    .HALF_DIV (HALF_DIV)
  ) u_shift (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .load_i (load),
    .word_i (word_mux),
    .sclk_o (sclk_o),
    .sdio_o (sdio_o),
    .done_o (sh_done)
  );

  // next-state process
  always_comb begin
    state_d  = state_q;
    idx_d    = idx_q;
    cnt_d    = cnt_q;
    load     = 1'b0;
    word_mux = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_INSTR;
          load     = 1'b1;
          word_mux = mk_instr(WRITE_FLAG, START_ADDR);
        end
      end
      ST_INSTR: begin
        if (sh_done) begin
          state_d  = ST_BURST;
          idx_d    = '0;
          load     = 1'b1;
          word_mux = rom_word;
        end
      end
      ST_BURST: begin
        if (sh_done) begin
          if (idx_q == AW'(N_WORDS - 1)) begin
            state_d = ST_GAP;
            cnt_d   = '0;
          end else begin
            idx_d    = idx_q + 1'b1;
            load     = 1'b1;
            word_mux = rom_word;
          end
        end
      end
      ST_GAP: begin
        if (cnt_q == CNW'(GAP_CYC - 1)) begin
          state_d  = ST_UPD_I;
          cnt_d    = '0;
          load     = 1'b1;
          word_mux = mk_instr(WRITE_FLAG, UPD_ADDR);
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_UPD_I: begin
        if (sh_done) begin
          state_d  = ST_UPD_D;
          load     = 1'b1;
          word_mux = UPD_DATA;
        end
      end
      ST_UPD_D: begin
        if (sh_done) begin
          state_d = ST_TRIG_H;
          cnt_d   = '0;
        end
      end
      ST_TRIG_H: begin
        if (cnt_q == CNW'(TRIG_CYC - 1)) begin
          state_d = ST_TRIG_L;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_TRIG_L: begin
        if (cnt_q == CNW'(TRIG_CYC - 1)) begin
          state_d = ST_FIN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_FIN: begin
        state_d = ST_IDLE;
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase
  end

  // output decode from next state, registered below
  always_comb begin
    cs_n_d = !(state_d == ST_INSTR || state_d == ST_BURST ||
               state_d == ST_UPD_I || state_d == ST_UPD_D);
    trig_d = (state_d == ST_TRIG_H);
    busy_d = (state_d != ST_IDLE) && (state_d != ST_FIN);
    done_d = (state_d == ST_FIN);
  end

  // register process
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      cs_n_q  <= 1'b1;
      trig_q  <= 1'b0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      cs_n_q  <= cs_n_d;
      trig_q  <= trig_d;
      busy_q  <= busy_d;
      done_q  <= done_d;
    end
  end

  assign cs_n_o = cs_n_q;
  assign trig_o = trig_q;
  assign busy_o = busy_q;
  assign done_o = done_q;

  AST_SCLK_UNDER_CS: assert property (@(posedge clk) disable iff (!rst_n_s)
    sclk_o |-> !cs_n_o); // R3

  AST_TRIG_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    trig_o |-> (cs_n_o && !sclk_o && busy_o)); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |=> !done_o); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n_s)
    done_o |-> !busy_o); // R8

  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (state_q != ST_IDLE && start_i) |=>
      (state_q != ST_INSTR || $past(state_q) == ST_INSTR)); // R9

endmodule

// File: tb/test_cfg_spi_loader.sv
module test_cfg_spi_loader;

  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 2;
  localparam int TRIG       = 16;
  localparam int NW         = 128;

  // {address, expected final word}
  localparam logic [31:0] VEC [8] = '{
    {16'h0000, 16'hC300}, {16'h0001, 16'hC201}, {16'h001C, 16'hDF1C},
    {16'h001D, 16'h0001}, {16'h001E, 16'hDD1E}, {16'h0040, 16'h8340},
    {16'h0055, 16'h9655}, {16'h007F, 16'hBC7F}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic sclk_o, cs_n_o, sdio_o, trig_o, busy_o, done_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_spi_loader i_cfg_spi_loader (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .sdio_o(sdio_o),
    .trig_o(trig_o), .busy_o(busy_o), .done_o(done_o)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  // behavioural slave and monitors
  bit          mon_en = 0;
  logic [15:0] mem [0:NW-1];
  logic [15:0] sh;
  logic [15:0] instr_w [0:3];
  int bitc, wcnt, tr, cur_addr, writes_total, last_wr;
  int words_in [0:3];
  int part_bits [0:3];
  int gap, edge_viol, hi_run, hi_bad, trig_hi, low_after, done_cyc, busy_bad;
  int tr_at_trig, last_at_trig, wr_at_trig;
  bit trig_seen, done_seen;
  logic prev_sclk, prev_sdio, prev_trig;

  task automatic clear_slave();
    for (int i = 0; i < NW; i++) mem[i] = 16'hxxxx;
    for (int i = 0; i < 4; i++) begin
      words_in[i] = -1; part_bits[i] = -1; instr_w[i] = 16'hxxxx;
    end
    bitc = 0; wcnt = 0; tr = 0; cur_addr = 0; writes_total = 0; last_wr = -1;
    gap = 0; edge_viol = 0; hi_run = 0; hi_bad = 0; trig_hi = 0;
    low_after = 0; done_cyc = 0; busy_bad = 0;
    tr_at_trig = -1; last_at_trig = -1; wr_at_trig = -1;
    trig_seen = 0; done_seen = 0;
  endtask

  always @(negedge cs_n_o) if (mon_en) begin
    bitc = 0; wcnt = 0;
  end

  always @(posedge cs_n_o) if (mon_en) begin
    if (tr < 4) begin words_in[tr] = wcnt; part_bits[tr] = bitc; end
    tr++;
  end

  always @(posedge sclk_o) if (mon_en && !cs_n_o) begin
    sh = {sh[14:0], sdio_o};
    bitc++;
    if (bitc == 16) begin
      bitc = 0;
      if (wcnt == 0) begin
        if (tr < 4) instr_w[tr] = sh;
        cur_addr = int'(sh[14:0]);
      end else begin
        if (cur_addr < NW) mem[cur_addr] = sh;
        last_wr = cur_addr;
        writes_total++;
        cur_addr++;
      end
      wcnt++;
    end
  end

  always @(negedge clk) begin
    if (mon_en) begin
      if (!cs_n_o && sclk_o && prev_sclk && sdio_o !== prev_sdio) edge_viol++;
      if (sclk_o) hi_run++;
      else begin
        if (hi_run != 0 && hi_run != HALF) hi_bad++;
        hi_run = 0;
      end
      if (tr == 1 && cs_n_o) gap++;
      if (done_o) begin done_seen = 1; done_cyc++; end
      if (trig_o && !prev_trig && !trig_seen) begin
        trig_seen = 1; tr_at_trig = tr; last_at_trig = last_wr;
        wr_at_trig = writes_total;
      end
      if (trig_o) begin
        trig_hi++;
        if (!busy_o) busy_bad++;
      end
      if (!trig_o && trig_seen && !done_seen) begin
        low_after++;
        if (!busy_o) busy_bad++;
      end
    end
    prev_sclk = sclk_o; prev_sdio = sdio_o; prev_trig = trig_o;
  end

  task automatic chk(input bit ok, input string req, input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic pulse_start();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done_o && n < 60000) begin @(negedge clk); n++; end
    chk(done_o === 1'b1, req, int'(done_o), 1);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    clear_slave();
    prev_trig = 1'b0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(cs_n_o === 1'b1, "R1 cs_n in reset", int'(cs_n_o), 1);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1 after release, no start
    chk(cs_n_o === 1'b1, "R1 cs_n idle", int'(cs_n_o), 1);
    chk(sclk_o === 1'b0, "R1 sclk idle", int'(sclk_o), 0);
    chk(trig_o === 1'b0, "R1 trig idle", int'(trig_o), 0);
    chk(busy_o === 1'b0, "R1 busy idle", int'(busy_o), 0);
    chk(done_o === 1'b0, "R1 done idle", int'(done_o), 0);
    mon_en = 1;

    pulse_start();
    chk(busy_o === 1'b1, "R8 busy after start", int'(busy_o), 1);
    while (writes_total < 40) @(negedge clk);
    pulse_start(); // R9 start while busy
    wait_done("R8 done reached");
    chk(busy_o === 1'b0, "R8 busy low with done", int'(busy_o), 0);
    @(negedge clk);
    chk(done_o === 1'b0, "R8 done one cycle", int'(done_o), 0);
    repeat (20) @(negedge clk);
    chk(tr == 2, "R9 transaction count", tr, 2);
    chk(done_cyc == 1, "R8 done cycles", done_cyc, 1);
    chk(busy_bad == 0, "R8 busy through trigger", busy_bad, 0);

    chk(instr_w[0] === 16'h0000, "R3 burst instruction", int'(instr_w[0]), 16'h0000);
    chk(words_in[0] == NW + 1, "R3 burst word count", words_in[0], NW + 1);
    chk(part_bits[0] == 0 && part_bits[1] == 0, "R2 whole words", part_bits[0] + part_bits[1], 0);
    chk(edge_viol == 0, "R2 data stable while sclk high", edge_viol, 0);
    chk(hi_bad == 0, "R2 sclk high phase", hi_bad, 0);
    chk(gap >= 4 * HALF, "R5 cs gap", gap, 4 * HALF);
    chk(words_in[1] == 2, "R6 commit word count", words_in[1], 2);
    chk(instr_w[1] === 16'h001D, "R6 commit instruction", int'(instr_w[1]), 16'h001D);
    chk(tr_at_trig == 2, "R7 trigger after commit", tr_at_trig, 2);
    chk(last_at_trig == 16'h1D, "R7 last write before trigger", last_at_trig, 16'h1D);
    chk(wr_at_trig == NW + 1, "R7 writes before trigger", wr_at_trig, NW + 1);
    chk(trig_hi == TRIG, "R7 trigger high width", trig_hi, TRIG);
    chk(low_after == TRIG, "R7 trigger low width", low_after, TRIG);

    // R4 / R6 table walk
    for (int v = 0; v < 8; v++) begin
      int a;
      a = int'(VEC[v][31:16]);
      chk(mem[a] === VEC[v][15:0], (a == 16'h1D) ? "R6 update register" : "R4 table word",
          int'(mem[a]), int'(VEC[v][15:0]));
    end
    begin
      int bad = 0;
      for (int a = 0; a < NW; a++) begin
        logic [7:0] b;
        b = 8'(a);
        if (a != 16'h1D && mem[a] !== {b ^ 8'hC3, b}) bad++;
      end
      chk(bad == 0, "R4 all addresses", bad, 0);
    end

    // R10 second run
    clear_slave();
    pulse_start();
    wait_done("R10 second done");
    repeat (4) @(negedge clk);
    chk(words_in[0] == NW + 1, "R10 second burst count", words_in[0], NW + 1);
    chk(mem[NW-1] === 16'hBC7F, "R10 last word", int'(mem[NW-1]), 16'hBC7F);
    chk(mem[16'h1D] === 16'h0001, "R10 update register", int'(mem[16'h1D]), 1);

    finished = 1;
    summary();
    $finish;
  end

endmodule